// File: doc/BRIEF.md
# Third-Order Multilevel Fractional-N Modulator

This block converts a 20-bit unsigned fractional frequency setting into a noise-shaped stream of integer levels from 0 to 8. A fractional-N PLL consumes that stream one level per update, as a fraction of eighths. Three cascaded integrators, each scaled by shift-and-add feedback, drive a clamped nine-level quantizer. Averaged over time, the level equals the setting divided by 131072, so the usable range covers roughly 0.46 to 7.48 eighths.

A controlling loop loads new settings through a strobe. Each loaded value is clamped to the range where the modulator stays stable. An external tick marks every write interval; the interval is a whole multiple of 1 us, because the divider repeats its eighths pattern over eight 125 ns reference periods. On each tick the modulator advances by one step and produces one 32-bit divider register word. That word is flagged valid for one cycle, but only while the run enable is high.

Top module: `fracn_dsm3`

## Requirements
- R1: After reset, `wr_valid` is low and `div_word` is 0x00000000, all three integrators are zero, and the active setting equals the `INIT_SETTING` parameter (default 478151).
- R2: When `load` is high, the setting takes `setting_in` clamped to the range 60000 to 980000 inclusive. A value below 60000 becomes 60000 and a value above 980000 becomes 980000.
- R3: On each tick the level is computed from the third integrator s3 as (s3*16 + s3*2) arithmetically shifted right by 13 in 32-bit signed arithmetic, then clamped to 0..8.
- R4: On the same tick, with q the level just computed and the old values of s1, s2 and s3, the integrators update as follows: s3 += (s2 >>> 5) - 768*q, s2 += (s1 >>> 5) - 16384*q, s1 += setting - 131072*q. All are 32-bit signed and wrap on overflow.
- R5: Level 0 is encoded as 0x00000007. Level k from 1 to 8 is encoded as bit 31 set, bits 10:8 equal to k-1, and bits 7:0 equal to 0x07; all other bits are 0.
- R6: A tick taken while `run` is high produces `wr_valid` high for exactly the one cycle after the tick, with `div_word` carrying that tick's encoded level.
- R7: A tick taken while `run` is low still advances the integrators and updates `div_word`, but `wr_valid` stays low.
- R8: Between ticks, `div_word` holds its value and `wr_valid` stays low, whatever `load` and `setting_in` do.
- R9: If a load and a tick arrive in the same cycle, that tick uses the previous setting, and the new setting applies from the next tick onward.
- R10: Over a long run with a constant setting S, the mean emitted level is within 0.05 of S/131072.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| setting_in | input | 20 | Unsigned fractional frequency setting |
| load | input | 1 | Latches the clamped `setting_in` |
| run | input | 1 | Enables write strobes |
| tick | input | 1 | One-cycle marker of each write interval |
| div_word | output | 32 | Encoded divider register word |
| wr_valid | output | 1 | One-cycle write strobe |

## Verification
The modulator is run from the reset setting, a mid-range setting, a setting below the low clamp, a setting above the high clamp, and settings exactly on both clamp edges. Comparing the emitted words with an independent step model separates a correct clamp, quantizer, update order and encoding from a design that uses fresh rather than old integrator values, or that maps level codes off by one. Ticks are also given back to back and spaced apart, with the enable dropped for part of a run, and with a load in the same cycle as a tick. These show whether state advances without a strobe and whether the word holds between intervals. A long constant-setting run then compares the mean level with S/131072, which would expose a wrong feedback weight that a short sequence could still match by chance.

// File: rtl/fracn_dsm3.sv
module fracn_dsm3 #(
  parameter int IN_W         = 20,
  parameter int ACC_W        = 32,
  parameter int MAX_LVL      = 8,
  parameter int SET_MIN      = 60000,
  parameter int SET_MAX      = 980000,
  parameter int INIT_SETTING = 478151
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IN_W-1:0]   setting_in,
  input  logic              load,
  input  logic              run,
  input  logic              tick,
  output logic [31:0]       div_word,
  output logic              wr_valid
);
  localparam int LVL_W = $clog2(MAX_LVL + 1);
  localparam logic [IN_W-1:0] LO = IN_W'(SET_MIN);
  localparam logic [IN_W-1:0] HI = IN_W'(SET_MAX);
  localparam logic [IN_W-1:0] INIT_C =
    (INIT_SETTING < SET_MIN) ? LO : (INIT_SETTING > SET_MAX) ? HI : IN_W'(INIT_SETTING);

  logic [IN_W-1:0]         setting_q;
  logic signed [ACC_W-1:0] s1, s2, s3;
  logic signed [ACC_W-1:0] prod, qraw, lvl_x;
  logic [LVL_W-1:0]        lvl;
  logic [31:0]             word_n;

  assign prod  = (s3 <<< 4) + (s3 <<< 1);
  assign qraw  = prod >>> 13;
  assign lvl   = (qraw < 0) ? '0 :
                 (qraw > MAX_LVL) ? LVL_W'(MAX_LVL) : qraw[LVL_W-1:0];
  assign lvl_x = ACC_W'(lvl);

  assign word_n = (lvl == '0) ? 32'h0000_0007
                              : (32'h8000_0007 | (32'(lvl - 1'b1) << 8));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      setting_q <= INIT_C;
    end else if (load) begin
      if (setting_in < LO)      setting_q <= LO;
      else if (setting_in > HI) setting_q <= HI;
      else                      setting_q <= setting_in;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1 <= '0;
      s2 <= '0;
      s3 <= '0;
    end else if (tick) begin
      s3 <= s3 + (s2 >>> 5) - (lvl_x <<< 9) - (lvl_x <<< 8);
      s2 <= s2 + (s1 >>> 5) - (lvl_x <<< 14);
      s1 <= s1 + ACC_W'(setting_q) - (lvl_x <<< 17);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_word <= '0;
      wr_valid <= 1'b0;
    end else begin
      wr_valid <= tick && run;
      if (tick) div_word <= word_n;
    end
  end
endmodule

module fracn_dsm3_chk #(
  parameter int IN_W    = 20,
  parameter int SET_MIN = 60000,
  parameter int SET_MAX = 980000
) (
  input logic            clk,
  input logic            rst_n,
  input logic            run,
  input logic            tick,
  input logic [IN_W-1:0] setting_q,
  input logic [31:0]     div_word,
  input logic            wr_valid
);
  p_strobe_source_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> ($past(tick) && $past(run)));

  p_quiet_when_stopped_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !wr_valid);

  p_hold_between_ticks_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> ($stable(div_word) && !wr_valid));

  p_word_format_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> (div_word[7:0] == 8'h07 && div_word[30:11] == '0 &&
                  (div_word[31] || div_word[10:8] == 3'd0)));

  p_setting_in_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(setting_q) >= SET_MIN) && (32'(setting_q) <= SET_MAX));
endmodule

bind fracn_dsm3 fracn_dsm3_chk #(.IN_W(IN_W), .SET_MIN(SET_MIN), .SET_MAX(SET_MAX)) u_chk (
  .clk(clk), .rst_n(rst_n), .run(run), .tick(tick),
  .setting_q(setting_q), .div_word(div_word), .wr_valid(wr_valid)
);

// File: tb/test_fracn_dsm3.sv
module test_fracn_dsm3;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [19:0] setting_in = '0;
  logic        load = 1'b0;
  logic        run = 1'b0;
  logic        tick = 1'b0;
  logic [31:0] div_word;
  logic        wr_valid;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  fracn_dsm3 i_fracn_dsm3 (
    .clk(clk), .rst_n(rst_n), .setting_in(setting_in), .load(load),
    .run(run), .tick(tick), .div_word(div_word), .wr_valid(wr_valid)
  );

  int m_set, m1, m2, m3;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic [31:0] last_word;
  longint      lvl_sum;
  int          lvl_cnt;

  function automatic int clampv(int v);
    if (v < 60000) return 60000;
    if (v > 980000) return 980000;
    return v;
  endfunction

  function automatic logic [31:0] enc(int k);
    if (k == 0) return 32'h0000_0007;
    return 32'h8000_0007 | (32'(k - 1) << 8);
  endfunction

  function automatic int dec(logic [31:0] w);
    if (!w[31]) return 0;
    return int'(w[10:8]) + 1;
  endfunction

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic void model_step(string tag);
    int p, q;
    p = ((m3 * 16) + (m3 * 2)) >>> 13;
    q = (p < 0) ? 0 : (p > 8) ? 8 : p;
    if (run) begin
      exp_q.push_back(enc(q));
      tag_q.push_back(tag);
    end
    last_word = enc(q);
    m3 = m3 + (m2 >>> 5) - q * 768;
    m2 = m2 + (m1 >>> 5) - q * 16384;
    m1 = m1 + m_set - q * 131072;
  endfunction

  task automatic do_tick(string tag);
    @(negedge clk);
    tick = 1'b1;
    model_step(tag);
    @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic do_load(int v);
    @(negedge clk);
    load = 1'b1;
    setting_in = 20'(v);
    @(negedge clk);
    load = 1'b0;
    m_set = clampv(v);
  endtask

  task automatic load_and_tick(int v, string tag);
    @(negedge clk);
    load = 1'b1;
    setting_in = 20'(v);
    tick = 1'b1;
    model_step(tag);
    @(negedge clk);
    load = 1'b0;
    tick = 1'b0;
    m_set = clampv(v);
  endtask

  task automatic run_ticks(int n, string tag);
    for (int i = 0; i < n; i++) do_tick(tag);
  endtask

  task automatic hold_check(int gap);
    for (int i = 0; i < gap; i++) begin
      @(negedge clk);
      if (i == 1) begin
        load = 1'b1;
        setting_in = 20'd700000;
      end else begin
        load = 1'b0;
      end
      if (i > 0) begin
        chk(div_word == last_word, "R8", "word held between ticks", div_word, last_word);
        chk(!wr_valid, "R8", "no strobe between ticks", wr_valid, 0);
      end
    end
    load = 1'b0;
    m_set = 700000;
  endtask

  always @(negedge clk) begin
    if (rst_n && wr_valid) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R7", "unexpected strobe", 1, 0);
      end else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(div_word == e, t, "emitted word", div_word, e);
        lvl_sum += dec(div_word);
        lvl_cnt++;
      end
    end
  end

  initial begin
    #(20 * 200000);
    chk(1'b0, "R6", "watchdog expired", 0, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    m_set = 478151; m1 = 0; m2 = 0; m3 = 0;
    lvl_sum = 0; lvl_cnt = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!wr_valid, "R1", "valid after reset", wr_valid, 0);
    chk(div_word == 32'h0, "R1", "word after reset", div_word, 0);

    run = 1'b1;
    run_ticks(200, "R1/R3/R4/R5");
    do_tick("R6");
    @(negedge clk);
    chk(!wr_valid, "R6", "strobe lasts one cycle", wr_valid, 0);

    do_load(300000);
    run_ticks(150, "R4");
    do_load(10);
    run_ticks(150, "R2 low clamp");
    do_load(1048575);
    run_ticks(150, "R2 high clamp");
    do_load(60000);
    run_ticks(100, "R2 low edge");
    do_load(980000);
    run_ticks(100, "R2 high edge");

    run = 1'b0;
    do_load(400000);
    run_ticks(40, "R7");
    @(negedge clk);
    chk(div_word == last_word, "R7", "word advances while stopped", div_word, last_word);
    run = 1'b1;
    run_ticks(60, "R7 resume");

    do_tick("R8");
    hold_check(6);
    do_tick("R8 after gap");
    hold_check(4);
    run_ticks(30, "R8");

    load_and_tick(200000, "R9 old setting");
    run_ticks(80, "R9 new setting");

    do_load(500000);
    run_ticks(64, "R10 settle");
    @(negedge clk);
    @(negedge clk);
    lvl_sum = 0; lvl_cnt = 0;
    run_ticks(4096, "R10");
    @(negedge clk);
    @(negedge clk);
    begin
      real mean, want;
      mean = real'(lvl_sum) / real'(lvl_cnt);
      want = 500000.0 / 131072.0;
      chk((mean - want < 0.05) && (want - mean < 0.05), "R10", "mean level x1000",
          longint'(mean * 1000.0), longint'(want * 1000.0));
    end
    chk(exp_q.size() == 0, "R6", "all expected words emitted", exp_q.size(), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule